// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is the control unit of a 16-bit single-accumulator processor. A small step counter walks through numbered timing states. At every state the block drives the select code of the shared register bus and the load, increment, clear, read and write strobes of the datapath registers and of memory. It fetches an instruction word, decodes its three opcode bits and its indirect-address bit, reads the effective address when needed, and then executes one of three classes of instruction: memory-reference, register-reference and input/output. The longest instruction reaches state 6. The datapath and memory live outside the block. The block sees the instruction register contents and a few status bits, and nothing else.

The block also owns the interrupt-enable flip-flop and the pending-interrupt flip-flop. When interrupts are enabled and either peripheral flag is up, a request is latched during any execute state. The next instruction cycle is then replaced by a three-state service cycle: it stores the return address at memory word 0, sets the program counter to 1 and disables further interrupts. A halt instruction freezes the sequencer until reset.

Top module: `hw_seq_ctrl`

## Requirements
- R1: Reset clears the step counter, interrupt enable, pending interrupt and halt state. After reset, `t_count` is 0 and `ien`, `irq_r` and `halted` are low.
- R2: With no pending interrupt, state 0 drives bus select 2 (PC) with `ar_ld`. State 1 drives bus select 7 (memory) with `mem_rd`, `ir_ld` and `pc_inc`.
- R3: State 2 drives bus select 5 (IR) with `ar_ld`, and latches opcode = `ir_word[14:12]` and indirect = `ir_word[15]`.
- R4: In state 3, an opcode 0..6 with indirect=1 drives `mem_rd`, bus 7 and `ar_ld`. With indirect=0, state 3 drives no strobe and the counter moves on to state 4.
- R5: Opcodes 0, 1 and 2 drive `mem_rd`, bus 7 and `dr_ld` in state 4. In state 5 they drive `ac_fn` 1 (AND), 2 (ADD) or 3 (load) respectively, and the next state is 0.
- R6: Opcode 3 drives bus 4 (AC) with `mem_wr` in state 4. Opcode 4 drives bus 1 (AR) with `pc_ld` in state 4. Both return to state 0 next. `mem_rd` and `mem_wr` are never both high.
- R7: Opcode 5 drives bus 2 with `mem_wr` and `ar_inc` in state 4, then bus 1 with `pc_ld` in state 5, then returns to state 0.
- R8: Opcode 6 reads into DR in state 4 and drives `dr_inc` in state 5. In state 6 it drives bus 3 (DR) with `mem_wr`, and `pc_inc` equals `dr_zero`. No state above 6 is ever reached.
- R9: Opcode 7 with `ir_word[15]`=0 acts in state 3 on its low bits, then returns to state 0. Bit 11 gives `ac_fn` 5 (clear), bit 9 gives 6 (complement), bit 7 gives 7 (shift right), bit 6 gives 8 (shift left) and bit 5 gives 9 (increment); the first of these, in that order, wins. Bit 10 gives `e_fn` 1 (clear) and bit 8 gives `e_fn` 2 (complement); bit 10 wins. `pc_inc` is raised by bit 4 when `ac_neg`=0, bit 3 when `ac_neg`=1, bit 2 when `ac_zero`=1, and bit 1 when `e_flag`=0.
- R10: Opcode 7 with `ir_word[15]`=1 acts in state 3, then returns to state 0. Bit 11 gives `ac_fn` 4 and `fgi_clr`. Bit 10 gives bus 4, `outr_ld` and `fgo_clr`. Bit 9 with `fgi` gives `pc_inc`, and bit 8 with `fgo` gives `pc_inc`. Bit 7 sets `ien` and bit 6 clears it; clearing wins.
- R11: At a clock edge where `t_count` is 3 or more, `ien` is 1 and `fgi` or `fgo` is 1, `irq_r` becomes 1. Otherwise it is never set.
- R12: With `irq_r`=1, state 0 drives bus 2, `ar_clr` and `tr_ld`. State 1 drives bus 6 (TR), `mem_wr` and `pc_clr`. State 2 drives `pc_inc`. The next cycle is state 0 with `ien` and `irq_r` low.
- R13: Bit 0 of a register-reference instruction sets `halted`. While halted, `t_count` stays 0, bus select is 0, and every strobe is low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_word | input | 16 | Current instruction register contents |
| dr_zero | input | 1 | Data register equals zero |
| ac_neg | input | 1 | Accumulator sign bit |
| ac_zero | input | 1 | Accumulator equals zero |
| e_flag | input | 1 | Carry/extension flip-flop value |
| fgi | input | 1 | Input-ready flag |
| fgo | input | 1 | Output-ready flag |
| bus_sel | output | 3 | Bus source: 0 none, 1 AR, 2 PC, 3 DR, 4 AC, 5 IR, 6 TR, 7 memory |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ar_ld | output | 1 | Load address register from bus |
| ar_inc | output | 1 | Increment address register |
| ar_clr | output | 1 | Clear address register |
| pc_ld | output | 1 | Load program counter from bus |
| pc_inc | output | 1 | Increment program counter |
| pc_clr | output | 1 | Clear program counter |
| dr_ld | output | 1 | Load data register from bus |
| dr_inc | output | 1 | Increment data register |
| ir_ld | output | 1 | Load instruction register from bus |
| tr_ld | output | 1 | Load temporary register from bus |
| outr_ld | output | 1 | Load output character register |
| ac_fn | output | 4 | Accumulator operation code (0 hold, 1..9 as in R5, R9, R10) |
| e_fn | output | 2 | Extension flip-flop operation: 0 hold, 1 clear, 2 complement |
| fgi_clr | output | 1 | Clear input flag |
| fgo_clr | output | 1 | Clear output flag |
| ien | output | 1 | Interrupt enable state |
| irq_r | output | 1 | Pending interrupt state |
| halted | output | 1 | Sequencer halted |
| t_count | output | 4 | Current timing state |

## Verification
The bound checker watches, on every cycle, these properties: read/write exclusion, the state-0 fetch strobes, the bound on the step counter, the write-back and conditional skip in state 6, the latching of an interrupt request, the exit from the service cycle, and the silence and stickiness of the halt state. Several behaviours can only be shown by the bench's scenarios. These are the per-opcode schedules, the decode of every register-reference and I/O bit with its skip conditions true and false, the priority among simultaneous bits, and the direct versus indirect paths. For these, a behavioural model predicts every output each cycle while instruction sequences run.

// File: rtl/hw_seq_pkg.sv
package hw_seq_pkg;

    localparam int WORD_W  = 16;
    localparam int OPC_W   = 3;
    localparam int N_OPC   = 1 << OPC_W;
    localparam int LOW_W   = 12;
    localparam int N_STATE = 7;   // states 0..6 are the only ones reached

    // bit positions of register-reference operations (decoded by position)
    localparam int K_CLA = 11;
    localparam int K_CLE = 10;
    localparam int K_CMA = 9;
    localparam int K_CME = 8;
    localparam int K_CIR = 7;
    localparam int K_CIL = 6;
    localparam int K_INC = 5;
    localparam int K_SPA = 4;
    localparam int K_SNA = 3;
    localparam int K_SZA = 2;
    localparam int K_SZE = 1;
    localparam int K_HLT = 0;

    // bit positions of I/O operations
    localparam int K_INP = 11;
    localparam int K_OUT = 10;
    localparam int K_SKI = 9;
    localparam int K_SKO = 8;
    localparam int K_ION = 7;
    localparam int K_IOF = 6;

    typedef enum logic [2:0] {
        BUS_NONE = 3'd0,
        BUS_AR   = 3'd1,
        BUS_PC   = 3'd2,
        BUS_DR   = 3'd3,
        BUS_AC   = 3'd4,
        BUS_IR   = 3'd5,
        BUS_TR   = 3'd6,
        BUS_MEM  = 3'd7
    } bus_src_e;

    typedef enum logic [3:0] {
        AC_HOLD = 4'd0,
        AC_AND  = 4'd1,
        AC_ADD  = 4'd2,
        AC_LOAD = 4'd3,
        AC_INP  = 4'd4,
        AC_CLR  = 4'd5,
        AC_CMP  = 4'd6,
        AC_SHR  = 4'd7,
        AC_SHL  = 4'd8,
        AC_INC  = 4'd9
    } ac_fn_e;

    typedef enum logic [1:0] {
        E_HOLD = 2'd0,
        E_CLR  = 2'd1,
        E_CMP  = 2'd2
    } e_fn_e;

    typedef struct packed {
        bus_src_e bus;
        logic     mem_rd;
        logic     mem_wr;
        logic     ar_ld;
        logic     ar_inc;
        logic     ar_clr;
        logic     pc_ld;
        logic     pc_inc;
        logic     pc_clr;
        logic     dr_ld;
        logic     dr_inc;
        logic     ir_ld;
        logic     tr_ld;
        logic     outr_ld;
        ac_fn_e   ac_fn;
        e_fn_e    e_fn;
        logic     fgi_clr;
        logic     fgo_clr;
        logic     sc_clr;
        logic     halt_set;
        logic     ien_set;
        logic     ien_clr;
        logic     r_clr;
    } ctl_t;

endpackage

// File: rtl/hw_seq_timer.sv
module hw_seq_timer #(
    parameter int SC_W = 4,
    parameter int N_ST = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            hold,
    output logic [SC_W-1:0] cnt,
    output logic [N_ST-1:0] hot
);
    localparam logic [SC_W-1:0] ONE = SC_W'(1);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (hold) cnt <= cnt;
        else if (clr)  cnt <= '0;
        else           cnt <= cnt + ONE;
    end

    for (genvar g = 0; g < N_ST; g++) begin : g_dec
        localparam logic [SC_W-1:0] KV = SC_W'(g);
        assign hot[g] = (cnt == KV);
    end
endmodule

// File: rtl/hw_seq_opdec.sv
module hw_seq_opdec
    import hw_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OPC_W:0]   ir_top,
    output logic             ind,
    output logic [N_OPC-1:0] d_hot
);
    logic [OPC_W-1:0] opc;

    always_ff @(posedge clk) begin
        if (rst) begin
            ind <= 1'b0;
            opc <= '0;
        end else if (load) begin
            ind <= ir_top[OPC_W];
            opc <= ir_top[OPC_W-1:0];
        end
    end

    for (genvar g = 0; g < N_OPC; g++) begin : g_op
        localparam logic [OPC_W-1:0] OV = OPC_W'(g);
        assign d_hot[g] = (opc == OV);
    end
endmodule

// File: rtl/hw_seq_irq.sv
module hw_seq_irq (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hot_lo,
    input  logic       fgi,
    input  logic       fgo,
    input  logic       ien_set,
    input  logic       ien_clr,
    input  logic       r_clr,
    input  logic       halt_set,
    output logic       ien,
    output logic       irq_r,
    output logic       halted
);
    logic r_req;
    assign r_req = ~(|hot_lo) & ien & (fgi | fgo);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien    <= 1'b0;
            irq_r  <= 1'b0;
            halted <= 1'b0;
        end else begin
            if (ien_clr)      ien <= 1'b0;
            else if (ien_set) ien <= 1'b1;
            if (r_clr)        irq_r <= 1'b0;
            else if (r_req)   irq_r <= 1'b1;
            if (halt_set)     halted <= 1'b1;
        end
    end
endmodule

// File: rtl/hw_seq_ctl.sv
module hw_seq_ctl
    import hw_seq_pkg::*;
(
    input  logic [N_STATE-1:0] t_hot,
    input  logic [N_OPC-1:0]   d_hot,
    input  logic               ind,
    input  logic               irq_r,
    input  logic               halted,
    input  logic [LOW_W-1:0]   ir_lo,
    input  logic               dr_zero,
    input  logic               ac_neg,
    input  logic               ac_zero,
    input  logic               e_flag,
    input  logic               fgi,
    input  logic               fgo,
    output ctl_t               c
);
    always_comb begin
        c = '0;
        if (halted) begin
            c = '0;
        end else if (irq_r && t_hot[0]) begin
            c.bus = BUS_PC;  c.ar_clr = 1'b1; c.tr_ld = 1'b1;
        end else if (irq_r && t_hot[1]) begin
            c.bus = BUS_TR;  c.mem_wr = 1'b1; c.pc_clr = 1'b1;
        end else if (irq_r && t_hot[2]) begin
            c.pc_inc = 1'b1; c.ien_clr = 1'b1; c.r_clr = 1'b1; c.sc_clr = 1'b1;
        end else if (t_hot[0]) begin
            c.bus = BUS_PC;  c.ar_ld = 1'b1;
        end else if (t_hot[1]) begin
            c.bus = BUS_MEM; c.mem_rd = 1'b1; c.ir_ld = 1'b1; c.pc_inc = 1'b1;
        end else if (t_hot[2]) begin
            c.bus = BUS_IR;  c.ar_ld = 1'b1;
        end else if (t_hot[3]) begin
            if (d_hot[7] && !ind) begin
                c.sc_clr = 1'b1;
                if (ir_lo[K_CLA])      c.ac_fn = AC_CLR;
                else if (ir_lo[K_CMA]) c.ac_fn = AC_CMP;
                else if (ir_lo[K_CIR]) c.ac_fn = AC_SHR;
                else if (ir_lo[K_CIL]) c.ac_fn = AC_SHL;
                else if (ir_lo[K_INC]) c.ac_fn = AC_INC;
                if (ir_lo[K_CLE])      c.e_fn = E_CLR;
                else if (ir_lo[K_CME]) c.e_fn = E_CMP;
                c.pc_inc = (ir_lo[K_SPA] & ~ac_neg) | (ir_lo[K_SNA] & ac_neg)
                         | (ir_lo[K_SZA] & ac_zero) | (ir_lo[K_SZE] & ~e_flag);
                c.halt_set = ir_lo[K_HLT];
            end else if (d_hot[7]) begin
                c.sc_clr = 1'b1;
                if (ir_lo[K_INP]) begin
                    c.ac_fn = AC_INP; c.fgi_clr = 1'b1;
                end
                if (ir_lo[K_OUT]) begin
                    c.bus = BUS_AC; c.outr_ld = 1'b1; c.fgo_clr = 1'b1;
                end
                c.pc_inc  = (ir_lo[K_SKI] & fgi) | (ir_lo[K_SKO] & fgo);
                c.ien_set = ir_lo[K_ION];
                c.ien_clr = ir_lo[K_IOF];
            end else if (ind) begin
                c.bus = BUS_MEM; c.mem_rd = 1'b1; c.ar_ld = 1'b1;
            end
        end else if (t_hot[4]) begin
            if (d_hot[0] || d_hot[1] || d_hot[2] || d_hot[6]) begin
                c.bus = BUS_MEM; c.mem_rd = 1'b1; c.dr_ld = 1'b1;
            end
            if (d_hot[3]) begin
                c.bus = BUS_AC; c.mem_wr = 1'b1; c.sc_clr = 1'b1;
            end
            if (d_hot[4]) begin
                c.bus = BUS_AR; c.pc_ld = 1'b1; c.sc_clr = 1'b1;
            end
            if (d_hot[5]) begin
                c.bus = BUS_PC; c.mem_wr = 1'b1; c.ar_inc = 1'b1;
            end
        end else if (t_hot[5]) begin
            if (d_hot[0]) begin c.ac_fn = AC_AND;  c.sc_clr = 1'b1; end
            if (d_hot[1]) begin c.ac_fn = AC_ADD;  c.sc_clr = 1'b1; end
            if (d_hot[2]) begin c.ac_fn = AC_LOAD; c.sc_clr = 1'b1; end
            if (d_hot[5]) begin
                c.bus = BUS_AR; c.pc_ld = 1'b1; c.sc_clr = 1'b1;
            end
            if (d_hot[6]) c.dr_inc = 1'b1;
        end else if (t_hot[6]) begin
            c.bus = BUS_DR; c.mem_wr = 1'b1; c.pc_inc = dr_zero; c.sc_clr = 1'b1;
        end
    end
endmodule

// File: rtl/hw_seq_ctrl.sv
module hw_seq_ctrl
    import hw_seq_pkg::*;
#(
    parameter int SC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] ir_word,
    input  logic              dr_zero,
    input  logic              ac_neg,
    input  logic              ac_zero,
    input  logic              e_flag,
    input  logic              fgi,
    input  logic              fgo,
    output logic [2:0]        bus_sel,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              ar_ld,
    output logic              ar_inc,
    output logic              ar_clr,
    output logic              pc_ld,
    output logic              pc_inc,
    output logic              pc_clr,
    output logic              dr_ld,
    output logic              dr_inc,
    output logic              ir_ld,
    output logic              tr_ld,
    output logic              outr_ld,
    output logic [3:0]        ac_fn,
    output logic [1:0]        e_fn,
    output logic              fgi_clr,
    output logic              fgo_clr,
    output logic              ien,
    output logic              irq_r,
    output logic              halted,
    output logic [SC_W-1:0]   t_count
);
    logic [N_STATE-1:0] t_hot;
    logic [N_OPC-1:0]   d_hot;
    logic               ind;
    ctl_t               c;

    hw_seq_timer #(.SC_W(SC_W), .N_ST(N_STATE)) u_timer (
        .clk (clk), .rst (rst), .clr (c.sc_clr), .hold (halted),
        .cnt (t_count), .hot (t_hot)
    );

    hw_seq_opdec u_opdec (
        .clk    (clk),
        .rst    (rst),
        .load   (t_hot[2] & ~irq_r & ~halted),
        .ir_top (ir_word[WORD_W-1:LOW_W]),
        .ind    (ind),
        .d_hot  (d_hot)
    );

    hw_seq_irq u_irq (
        .clk (clk), .rst (rst), .hot_lo (t_hot[2:0]), .fgi (fgi), .fgo (fgo),
        .ien_set (c.ien_set), .ien_clr (c.ien_clr), .r_clr (c.r_clr),
        .halt_set (c.halt_set), .ien (ien), .irq_r (irq_r), .halted (halted)
    );

    hw_seq_ctl u_ctl (
        .t_hot (t_hot), .d_hot (d_hot), .ind (ind), .irq_r (irq_r),
        .halted (halted), .ir_lo (ir_word[LOW_W-1:0]), .dr_zero (dr_zero),
        .ac_neg (ac_neg), .ac_zero (ac_zero), .e_flag (e_flag),
        .fgi (fgi), .fgo (fgo), .c (c)
    );

    assign bus_sel = c.bus;
    assign mem_rd  = c.mem_rd;
    assign mem_wr  = c.mem_wr;
    assign ar_ld   = c.ar_ld;
    assign ar_inc  = c.ar_inc;
    assign ar_clr  = c.ar_clr;
    assign pc_ld   = c.pc_ld;
    assign pc_inc  = c.pc_inc;
    assign pc_clr  = c.pc_clr;
    assign dr_ld   = c.dr_ld;
    assign dr_inc  = c.dr_inc;
    assign ir_ld   = c.ir_ld;
    assign tr_ld   = c.tr_ld;
    assign outr_ld = c.outr_ld;
    assign ac_fn   = c.ac_fn;
    assign e_fn    = c.e_fn;
    assign fgi_clr = c.fgi_clr;
    assign fgo_clr = c.fgo_clr;
endmodule

// File: rtl/hw_seq_chk.sv
module hw_seq_chk #(
    parameter int SC_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            fgi,
    input logic            fgo,
    input logic            dr_zero,
    input logic [2:0]      bus_sel,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            ar_ld,
    input logic            pc_inc,
    input logic            ien,
    input logic            irq_r,
    input logic            halted,
    input logic [SC_W-1:0] t_count
);
    // R1: first sampled cycle after reset release shows the cleared state
    a_r1_reset_state: assert property (@(posedge clk)
        $fell(rst) |-> (t_count == 0 && !ien && !irq_r && !halted));

    a_r2_fetch_addr: assert property (@(posedge clk) disable iff (rst)
        (t_count == 0 && !irq_r && !halted) |-> (bus_sel == 3'd2 && ar_ld && !mem_wr));

    a_r6_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r8_state_bound: assert property (@(posedge clk) disable iff (rst)
        t_count <= 6);

    a_r8_isz_writeback: assert property (@(posedge clk) disable iff (rst)
        (t_count == 6) |-> (bus_sel == 3'd3 && mem_wr && (pc_inc == dr_zero)));

    a_r11_request_latch: assert property (@(posedge clk) disable iff (rst)
        (t_count >= 3 && ien && (fgi || fgo)) |=> irq_r);

    a_r12_service_exit: assert property (@(posedge clk) disable iff (rst)
        (irq_r && t_count == 2) |=> (!irq_r && !ien && t_count == 0));

    a_r13_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> (t_count == 0 && !mem_rd && !mem_wr && bus_sel == 3'd0));

    a_r13_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
endmodule

bind hw_seq_ctrl hw_seq_chk #(.SC_W(SC_W)) u_chk (.*);

// File: tb/hw_seq_ctrl_tb.sv
module hw_seq_ctrl_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic [15:0] ir_word;
    logic        dr_zero, ac_neg, ac_zero, e_flag, fgi, fgo;
    logic [2:0]  bus_sel;
    logic        mem_rd, mem_wr, ar_ld, ar_inc, ar_clr, pc_ld, pc_inc, pc_clr;
    logic        dr_ld, dr_inc, ir_ld, tr_ld, outr_ld, fgi_clr, fgo_clr;
    logic [3:0]  ac_fn;
    logic [1:0]  e_fn;
    logic        ien, irq_r, halted;
    logic [3:0]  t_count;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural model state
    int m_t = 0;
    int m_op = 0;
    bit m_i = 0, m_ien = 0, m_r = 0, m_halt = 0;

    hw_seq_ctrl u_dut (
        .clk(clk), .rst(rst), .ir_word(ir_word), .dr_zero(dr_zero),
        .ac_neg(ac_neg), .ac_zero(ac_zero), .e_flag(e_flag), .fgi(fgi), .fgo(fgo),
        .bus_sel(bus_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ar_ld(ar_ld),
        .ar_inc(ar_inc), .ar_clr(ar_clr), .pc_ld(pc_ld), .pc_inc(pc_inc),
        .pc_clr(pc_clr), .dr_ld(dr_ld), .dr_inc(dr_inc), .ir_ld(ir_ld),
        .tr_ld(tr_ld), .outr_ld(outr_ld), .ac_fn(ac_fn), .e_fn(e_fn),
        .fgi_clr(fgi_clr), .fgo_clr(fgo_clr), .ien(ien), .irq_r(irq_r),
        .halted(halted), .t_count(t_count)
    );

    task automatic check(input string tag, input logic [30:0] got, input logic [30:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, got, exp);
        end
    endtask

    task automatic cyc();
        logic [2:0]  xb;
        logic        xrd, xwr, xarl, xari, xarc, xpcl, xpci, xpcc;
        logic        xdrl, xdri, xirl, xtrl, xoutl, xfic, xfoc;
        logic [3:0]  xac;
        logic [1:0]  xe;
        logic [11:0] b;
        logic [30:0] ev, gv;
        string       tag;
        int          nt;
        bit          nien, nr, nh, rset;
        #1;
        b = ir_word[11:0];
        xb = 3'd0; xac = 4'd0; xe = 2'd0;
        {xrd, xwr, xarl, xari, xarc, xpcl, xpci, xpcc} = '0;
        {xdrl, xdri, xirl, xtrl, xoutl, xfic, xfoc} = '0;
        if (m_halt) begin
            tag = "R13";
        end else if (m_r && m_t <= 2) begin
            tag = "R12";
            if (m_t == 0) begin xb = 3'd2; xarc = 1; xtrl = 1; end
            else if (m_t == 1) begin xb = 3'd6; xwr = 1; xpcc = 1; end
            else xpci = 1;
        end else begin
            case (m_t)
                0: begin tag = "R2"; xb = 3'd2; xarl = 1; end
                1: begin tag = "R2"; xb = 3'd7; xrd = 1; xirl = 1; xpci = 1; end
                2: begin tag = "R3"; xb = 3'd5; xarl = 1; end
                3: begin
                    if (m_op == 7 && !m_i) begin
                        tag = b[0] ? "R13" : "R9";
                        if (b[11]) xac = 4'd5;
                        else if (b[9]) xac = 4'd6;
                        else if (b[7]) xac = 4'd7;
                        else if (b[6]) xac = 4'd8;
                        else if (b[5]) xac = 4'd9;
                        if (b[10]) xe = 2'd1;
                        else if (b[8]) xe = 2'd2;
                        xpci = (b[4] && !ac_neg) || (b[3] && ac_neg) ||
                               (b[2] && ac_zero) || (b[1] && !e_flag);
                    end else if (m_op == 7) begin
                        tag = "R10";
                        if (b[11]) begin xac = 4'd4; xfic = 1; end
                        if (b[10]) begin xb = 3'd4; xoutl = 1; xfoc = 1; end
                        xpci = (b[9] && fgi) || (b[8] && fgo);
                    end else begin
                        tag = "R4";
                        if (m_i) begin xb = 3'd7; xrd = 1; xarl = 1; end
                    end
                end
                default: begin
                    if (m_op <= 2) tag = "R5";
                    else if (m_op <= 4) tag = "R6";
                    else if (m_op == 5) tag = "R7";
                    else tag = "R8";
                    if (m_t == 4) begin
                        if (m_op <= 2 || m_op == 6) begin xb = 3'd7; xrd = 1; xdrl = 1; end
                        else if (m_op == 3) begin xb = 3'd4; xwr = 1; end
                        else if (m_op == 4) begin xb = 3'd1; xpcl = 1; end
                        else begin xb = 3'd2; xwr = 1; xari = 1; end
                    end else if (m_t == 5) begin
                        if (m_op <= 2) xac = 4'(m_op + 1);
                        else if (m_op == 5) begin xb = 3'd1; xpcl = 1; end
                        else xdri = 1;
                    end else begin
                        xb = 3'd3; xwr = 1; xpci = dr_zero;
                    end
                end
            endcase
        end
        if (rst) tag = "R1";
        ev = {xb, xrd, xwr, xarl, xari, xarc, xpcl, xpci, xpcc, xdrl, xdri, xirl,
              xtrl, xoutl, xac, xe, xfic, xfoc, m_ien, m_r, m_halt, 4'(m_t)};
        gv = {bus_sel, mem_rd, mem_wr, ar_ld, ar_inc, ar_clr, pc_ld, pc_inc, pc_clr,
              dr_ld, dr_inc, ir_ld, tr_ld, outr_ld, ac_fn, e_fn, fgi_clr, fgo_clr,
              ien, irq_r, halted, t_count};
        check(tag, gv, ev);

        // next state of the model
        nt = m_t; nien = m_ien; nr = m_r; nh = m_halt;
        rset = (m_t >= 3) && m_ien && (fgi || fgo) && !m_halt;
        if (rst) begin
            nt = 0; nien = 0; nr = 0; nh = 0; m_op = 0; m_i = 0;
        end else if (!m_halt) begin
            if (m_r && m_t == 2) begin
                nt = 0; nien = 0; nr = 0;
            end else if (m_t == 2) begin
                m_op = int'(ir_word[14:12]); m_i = ir_word[15]; nt = 3;
            end else if (m_t == 3) begin
                if (m_op == 7) begin
                    nt = 0;
                    if (!m_i && b[0]) nh = 1;
                    if (m_i && b[7]) nien = 1;
                    if (m_i && b[6]) nien = 0;
                end else nt = 4;
            end else if (m_t == 4) begin
                nt = (m_op == 3 || m_op == 4) ? 0 : 5;
            end else if (m_t == 5) begin
                nt = (m_op == 6) ? 6 : 0;
            end else if (m_t == 6) begin
                nt = 0;
            end else nt = m_t + 1;
            if (rset) nr = 1;
        end
        m_t = nt; m_ien = nien; m_r = nr; m_halt = nh;
        @(negedge clk);
    endtask

    task automatic run(input logic [15:0] w);
        int guard;
        ir_word = w;
        cyc();
        guard = 0;
        while (m_t != 0 && guard < 20) begin
            cyc();
            guard++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired (all requirements)");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; ir_word = 16'h0; dr_zero = 0; ac_neg = 0; ac_zero = 0;
        e_flag = 0; fgi = 0; fgo = 0;
        @(negedge clk);
        cyc(); cyc();
        rst = 0;
        // R1: state right after reset
        check("R1 reset state", {27'd0, ien, irq_r, halted, t_count}, 31'd0);

        // memory-reference: R4 R5 R6 R7 R8
        run(16'h2123);              // load, direct
        run(16'h9045);              // add, indirect
        run(16'h0010);              // and, direct
        run(16'hA050);              // load, indirect
        run(16'h3010);              // store
        run(16'hB011);              // store, indirect
        run(16'h4020);              // branch
        run(16'h5030);              // branch-and-save
        dr_zero = 0; run(16'h6040); // increment-skip, no skip (R8)
        dr_zero = 1; run(16'hE041); // increment-skip, skip (R8)
        dr_zero = 0;

        // register-reference, every bit with conditions false then true (R9)
        for (int k = 11; k >= 1; k--) begin
            ac_neg = 0; ac_zero = 0; e_flag = 0;
            run(16'h7000 | (16'h1 << k));
            ac_neg = 1; ac_zero = 1; e_flag = 1;
            run(16'h7000 | (16'h1 << k));
        end
        ac_neg = 0; ac_zero = 0; e_flag = 0;
        run(16'h7C00);              // clear AC and E together (R9)
        run(16'h7AA0);              // several AC bits: clear wins (R9)

        // I/O (R10)
        run(16'hF800);
        run(16'hF400);
        run(16'hF200);
        run(16'hF100);
        fgi = 1; fgo = 1;
        run(16'hF200);
        run(16'hF100);
        fgi = 0; fgo = 0;
        run(16'hF080);
        check("R10 enable set", {30'd0, ien}, 31'd1);
        run(16'hF040);
        check("R10 enable clear", {30'd0, ien}, 31'd0);
        run(16'hF0C0);              // both: clear wins
        check("R10 clear wins", {30'd0, ien}, 31'd0);

        // interrupt with input flag (R11 R12)
        fgi = 1;
        run(16'h7800);              // ien=0: no request
        check("R11 no request while disabled", {30'd0, irq_r}, 31'd0);
        fgi = 0;
        run(16'hF080);
        fgi = 1;
        run(16'h7800);
        check("R11 request latched", {30'd0, irq_r}, 31'd1);
        fgi = 0;
        run(16'h0000);              // service cycle
        check("R12 after service", {28'd0, ien, irq_r, t_count[0]}, 31'd0);

        // interrupt with output flag during a long instruction (R11 R12)
        run(16'hF080);
        fgo = 1;
        run(16'h6040);
        check("R11 request via output flag", {30'd0, irq_r}, 31'd1);
        fgo = 0;
        run(16'h0000);

        // halt (R13)
        run(16'h7001);
        check("R13 halted", {30'd0, halted}, 31'd1);
        ir_word = 16'h2000;
        repeat (5) cyc();
        check("R13 still halted", {26'd0, halted, t_count}, {26'd0, 1'b1, 4'd0});
        rst = 1;
        cyc();
        rst = 0;
        check("R1 reset releases halt", {27'd0, ien, irq_r, halted, t_count}, 31'd0);
        run(16'h2123);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule